// File: doc/BRIEF.md
# SAR Converter Serial Readout Port

This block is the digital readout side of a 16-bit successive-approximation converter. A host raises the convert strobe `cnv` to start a conversion. The level of `sdi` at that moment sets how the result will be read. With `sdi` high the port runs in select mode: `cnv` held low acts as the chip select. With `sdi` low it runs in chain mode: the port behaves as one stage of a shift-register chain, so several converters can share one three-wire bus.

A cycle counter stands in for the conversion time. When it expires, the port captures the conversion result from `conv_result` and makes the first bit available. No earlier sample is held back, so the word that is read always belongs to the conversion just finished. Each falling edge of `sck` moves the next bit onto `sdo`, most significant bit first.

If `start_bit_en` is high when the conversion starts, the port adds a busy indicator. While the conversion runs, `sdo` is driven high. At the end, a single zero start bit goes out ahead of the data. There is no true tri-state: `sdo_oe` marks the windows in which `sdo` would be driven. The inputs `cnv`, `sdi` and `sck` are sampled on `clk`.

Top module: `sar_serial_port`

## Requirements
- R1: A rising edge of `cnv` outside a conversion starts one. `sdi` high at that edge selects select mode and `sdi` low selects chain mode. `start_bit_en` is captured at the same edge.
- R2: While `cnv` is high, `sdo_oe` is 0.
- R3: A conversion lasts CONV_CYCLES clocks. At expiry the port loads the value on `conv_result` at that moment. Changes to `conv_result` after that point do not alter the word being read. Without the start bit, `sdo_oe` stays 0 until expiry and rises at expiry if `cnv` is low.
- R4: With the start bit enabled, `sdo_oe` is 1 and `sdo` is 1 while a conversion runs with `cnv` low. After expiry the first bit on `sdo` is 0, followed by the data.
- R5: Data is straight binary, most significant bit first. The first data bit is on `sdo` as soon as the conversion ends. Each `sck` falling edge, taken while `cnv` is low, advances `sdo` by exactly one bit.
- R6: In select mode, `sdo_oe` falls after the 16th `sck` falling edge, or after the 17th when the start bit is enabled.
- R7: In select mode, a rising edge on `sdi` during readout ends it, and `sdo_oe` falls.
- R8: In chain mode, the level on `sdi` at each `sck` falling edge enters behind the local word. It appears on `sdo` directly after the last local bit. Readout does not end on its own.
- R9: A rising edge of `cnv` during a conversion is ignored. It changes neither the mode nor the conversion timing.
- R10: After reset, `sdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv | input | 1 | Convert strobe; low level enables the output |
| sdi | input | 1 | Mode select at `cnv` rise, end-of-read in select mode, upstream data in chain mode |
| sck | input | 1 | Serial clock; bits advance on its falling edge |
| start_bit_en | input | 1 | Enables the busy indicator and start bit for the next conversion |
| conv_result | input | DATA_W | Result from the behavioural conversion model |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | High where `sdo` is driven, low where it would be high impedance |

## Verification
The bench changes `conv_result` one cycle before expiry and again during readout. A port that latched the value at the strobe, or kept sampling it, would read back the wrong word. It pulses `cnv` in the middle of a select-mode conversion with `sdi` low. A port that accepted that edge would switch to chain mode, and `sdo_oe` would stay high past the last bit. Chain reads clock random upstream bits through and expect them directly behind the local word. An off-by-one in where the shift register is tapped would lose or repeat a bit at the seam. The test of `sdi` ending the read early, and the end-of-word checks with and without the start bit, catch a bit counter that stops one edge early or late.

// File: rtl/sar_serial_port.sv
module sar_serial_port #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv,
  input  logic              sdi,
  input  logic              sck,
  input  logic              start_bit_en,
  input  logic [DATA_W-1:0] conv_result,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int SH_W  = DATA_W + 1;
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam int BIT_W = $clog2(SH_W + 1);
  localparam logic [1:0] S_IDLE = 2'd0;
  localparam logic [1:0] S_CONV = 2'd1;
  localparam logic [1:0] S_READ = 2'd2;

  logic [1:0]       st;
  logic [CNT_W-1:0] cnt;
  logic [SH_W-1:0]  sh;
  logic [BIT_W-1:0] bits;
  logic             cnv_q, sck_q, sdi_q, chain, busy;

  wire cnv_rise = cnv & ~cnv_q;
  wire sck_fall = ~sck & sck_q;
  wire sdi_rise = sdi & ~sdi_q;
  wire [BIT_W-1:0] nbits = busy ? BIT_W'(SH_W) : BIT_W'(DATA_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnv_q <= 1'b0;
      sck_q <= 1'b0;
      sdi_q <= 1'b0;
    end else begin
      cnv_q <= cnv;
      sck_q <= sck;
      sdi_q <= sdi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      sh    <= '0;
      bits  <= '0;
      chain <= 1'b0;
      busy  <= 1'b0;
    end else if (cnv_rise && st != S_CONV) begin
      st    <= S_CONV;
      cnt   <= CNT_W'(CONV_CYCLES);
      chain <= ~sdi;
      busy  <= start_bit_en;
      bits  <= '0;
    end else begin
      case (st)
        S_CONV: begin
          if (cnt <= CNT_W'(1)) begin
            st  <= S_READ;
            sh  <= {1'b0, conv_result};
            cnt <= '0;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        S_READ: begin
          if (!chain && sdi_rise) begin
            st <= S_IDLE;
          end else if (sck_fall && !cnv) begin
            sh <= {sh[SH_W-2:0], sdi};
            if (bits < nbits) bits <= bits + BIT_W'(1);
            if (!chain && (bits + BIT_W'(1)) == nbits) st <= S_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign sdo    = (st == S_CONV) ? 1'b1 : (busy ? sh[SH_W-1] : sh[SH_W-2]);
  assign sdo_oe = ~cnv & (((st == S_CONV) & busy) | (st == S_READ));
endmodule

// File: rtl/sar_serial_port_chk.sv
module sar_serial_port_chk #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 110,
  parameter int CNT_W       = 7,
  parameter int BIT_W       = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnv,
  input logic             cnv_q,
  input logic             sdi,
  input logic             sdo,
  input logic             sdo_oe,
  input logic [1:0]       st,
  input logic [CNT_W-1:0] cnt,
  input logic             chain,
  input logic [BIT_W-1:0] bits,
  input logic [BIT_W-1:0] nbits
);
  AST_OE_OFF_WHILE_CNV: assert property (@(posedge clk) disable iff (!rst_n)
    cnv |-> !sdo_oe); // R2
  AST_BUSY_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && sdo_oe) |-> sdo); // R4
  AST_MODE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv && !cnv_q && st != 2'd1) |=> (chain == !$past(sdi))); // R1
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1) |-> (cnt >= CNT_W'(1) && cnt <= CNT_W'(CONV_CYCLES))); // R3
  AST_BITS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    bits <= nbits); // R6
  AST_CONV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && cnt > CNT_W'(1)) |=> (st == 2'd1 && $stable(chain))); // R9
  AST_WIDTH_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (nbits == BIT_W'(DATA_W) || nbits == BIT_W'(DATA_W + 1))); // R4
endmodule

bind sar_serial_port sar_serial_port_chk #(
  .DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES), .CNT_W(CNT_W), .BIT_W(BIT_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .cnv(cnv), .cnv_q(cnv_q), .sdi(sdi),
  .sdo(sdo), .sdo_oe(sdo_oe), .st(st), .cnt(cnt), .chain(chain),
  .bits(bits), .nbits(nbits)
);

// File: tb/test_sar_serial_port.sv
module test_sar_serial_port;
  localparam int W = 16;
  localparam int C = 110;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cnv = 1'b0, sdi = 1'b1, sck = 1'b0, start_bit_en = 1'b0;
  logic [W-1:0] conv_result = '0;
  logic sdo, sdo_oe;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  sar_serial_port #(.DATA_W(W), .CONV_CYCLES(C)) i_sar_serial_port (
    .clk(clk), .rst_n(rst_n), .cnv(cnv), .sdi(sdi), .sck(sck),
    .start_bit_en(start_bit_en), .conv_result(conv_result),
    .sdo(sdo), .sdo_oe(sdo_oe));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [W-1:0] d, input logic busy, input int i, input logic [63:0] up);
    int nb = W + int'(busy);
    if (i < nb) return busy ? ((i == 0) ? 1'b0 : d[W-i]) : d[W-1-i];
    return up[i-nb];
  endfunction

  task automatic start_conv(input logic chain, input logic busy, input logic [W-1:0] d);
    @(negedge clk);
    conv_result = d; start_bit_en = busy; sdi = ~chain; cnv = 1'b1;
    @(negedge clk) cnv = 1'b0;
    repeat (C + 1) @(negedge clk);
  endtask

  task automatic sck_pulse(input logic chain, input logic ub);
    sck = 1'b1;
    if (chain) sdi = ub;
    @(negedge clk) sck = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic read_word(input logic chain, input logic busy, input logic [W-1:0] d,
                           input logic [63:0] up, input int extra, input string req);
    int nb = W + int'(busy);
    int total = nb + (chain ? extra : 0);
    logic [63:0] got = '0, exp = '0;
    bit oe_ok = 1'b1;
    for (int i = 0; i < total; i++) begin
      if (i > 0) sck_pulse(chain, up[i-1]);
      got[i] = sdo;
      exp[i] = exp_bit(d, busy, i, up);
      if (sdo_oe !== 1'b1) oe_ok = 1'b0;
    end
    chk(got == exp && oe_ok, req, got, exp);
    if (!chain) begin
      sck_pulse(1'b0, 1'b0);
      chk(sdo_oe == 1'b0, "R6 oe drops after last bit", 64'(sdo_oe), 64'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", checks, checks);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    chk(sdo_oe == 1'b0, "R10 reset oe", 64'(sdo_oe), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 timing and late result capture
    @(negedge clk);
    conv_result = 16'h1111; start_bit_en = 1'b0; sdi = 1'b1; cnv = 1'b1;
    @(negedge clk) cnv = 1'b0;
    repeat (C - 2) @(negedge clk);
    chk(sdo_oe == 1'b0, "R3 not driven before expiry", 64'(sdo_oe), 64'd0);
    conv_result = 16'hB00C;
    repeat (2) @(negedge clk);
    chk(sdo_oe == 1'b1, "R3 driven at expiry", 64'(sdo_oe), 64'd1);
    conv_result = 16'h0F0F;
    read_word(1'b0, 1'b0, 16'hB00C, 64'd0, 0, "R3 R5 result captured at expiry");

    // R4 busy indicator during conversion
    @(negedge clk);
    conv_result = 16'h8001; start_bit_en = 1'b1; sdi = 1'b1; cnv = 1'b1;
    @(negedge clk) cnv = 1'b0;
    repeat (C / 2) @(negedge clk);
    chk(sdo_oe == 1'b1 && sdo == 1'b1, "R4 busy high", {62'd0, sdo_oe, sdo}, 64'd3);
    repeat (C / 2 + 2) @(negedge clk);
    read_word(1'b0, 1'b1, 16'h8001, 64'd0, 0, "R4 start bit then data");

    // R2 cnv high blocks output
    start_conv(1'b0, 1'b0, 16'hFFFF);
    cnv = 1'b1;
    @(negedge clk);
    chk(sdo_oe == 1'b0, "R2 cnv high blocks output", 64'(sdo_oe), 64'd0);
    cnv = 1'b0;
    @(negedge clk);

    // R7 sdi rise ends select-mode read
    start_conv(1'b0, 1'b0, 16'hA5A5);
    sdi = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 5; k++) sck_pulse(1'b0, 1'b0);
    chk(sdo_oe == 1'b1, "R7 still reading", 64'(sdo_oe), 64'd1);
    sdi = 1'b1;
    repeat (2) @(negedge clk);
    chk(sdo_oe == 1'b0, "R7 sdi rise ends read", 64'(sdo_oe), 64'd0);

    // R9 cnv rise during conversion ignored
    @(negedge clk);
    conv_result = 16'h3C5A; start_bit_en = 1'b0; sdi = 1'b1; cnv = 1'b1;
    @(negedge clk) cnv = 1'b0;
    repeat (20) @(negedge clk);
    sdi = 1'b0; cnv = 1'b1;
    @(negedge clk) cnv = 1'b0;
    @(negedge clk) sdi = 1'b1;
    repeat (C - 24) @(negedge clk);
    chk(sdo_oe == 1'b0, "R9 timing unchanged before expiry", 64'(sdo_oe), 64'd0);
    repeat (3) @(negedge clk);
    read_word(1'b0, 1'b0, 16'h3C5A, 64'd0, 0, "R9 mode kept after second strobe");

    // R8 directed chain pass-through
    start_conv(1'b1, 1'b0, 16'h0001);
    read_word(1'b1, 1'b0, 16'h0001, 64'hFFFF_0000_DEAD_BEEF, 20, "R8 chain pass-through");
    start_conv(1'b1, 1'b1, 16'hFFFE);
    read_word(1'b1, 1'b1, 16'hFFFE, 64'h0000_0000_0000_5555, 16, "R8 R4 chain with start bit");

    // R1 R5 R6 R8 random mix
    for (int n = 0; n < 30; n++) begin
      logic ch = 1'($urandom);
      logic bz = 1'($urandom);
      logic [W-1:0] d = W'($urandom);
      logic [63:0] up = {$urandom, $urandom};
      int ex = int'($urandom_range(1, 24));
      start_conv(ch, bz, d);
      read_word(ch, bz, d, up, ex, ch ? "R1 R8 random chain word" : "R1 R5 random select word");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule